// File: doc/BRIEF.md
# Word-Granularity Registration Coherence Controller

This block keeps the coherence state of every word in a private stash or first-level data store under a registration-based protocol meant for data-race-free programs. Each word carries one of four 2-bit codes: Invalid (00), Valid (01), Registered (10) and Writeback (11). There are no transient states and no incoming invalidations. A read of a word that holds no data asks for it from the shared last-level cache. A write takes ownership of the word at once and, when the word was not already owned, sends a registration that names this core and the map entry the data belongs to.

Fill data from the shared cache arrives a line at a time with a per-word mask, so partial lines merge word by word: words this core owns keep their local values. A writeback moves an owned word into the Writeback state. Its completion then frees the word. At each phase or kernel boundary, one pulse clears every word that is not owned, all in the same cycle, while owned words survive into the next phase.

Top module: `wcoh_ctrl`

## Requirements
- R1: After reset every word is Invalid (code 00). A read of any word misses and issues a fetch request for that index.
- R2: One cycle after a read, `rsp_valid` is 1. If the word is Valid, Registered or Writeback, `rsp_hit` is 1 and `rsp_rdata` holds its data. If the word is Invalid, `rsp_hit` is 0 and, in the same cycle, `fetch_req_valid` is 1 with `fetch_req_idx` equal to the read index.
- R3: A fill covers word `fill_line*WPL + k` when bit k of `fill_mask` is set, and carries that word's data in `fill_data[k*DATA_W +: DATA_W]`. Covered Invalid and Valid words take the fill data and become Valid (code 01). Covered Registered and Writeback words keep both their data and their state.
- R4: A write stores its data and makes the word Registered (code 10) from any state. One cycle later, if the word was not already Registered, `reg_req_valid` pulses with the word index, `core_id` and `acc_map_id`.
- R5: Reads and writes to a Registered word leave it Registered. A write to a Registered word sends no registration.
- R6: A `phase_end` pulse turns every word that is not Registered to Invalid in one cycle. Registered words keep their state and data, and so does a word written in the same cycle as the pulse.
- R7: `wb_start` on a Registered word moves it to Writeback (code 11). One cycle later `wb_req_valid` pulses with the index, the data and the map ID stored by the last write. On a word in any other state, `wb_start` is ignored and no request appears. Reads of a word in Writeback still hit.
- R8: `wb_done` on a word in Writeback makes it Invalid. On a word in any other state it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_id | input | CORE_W | ID of this core, sent in registrations |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | IDX_W | Word index of the access |
| acc_wdata | input | DATA_W | Write data |
| acc_map_id | input | MAP_W | Map entry ID of the access |
| rsp_valid | output | 1 | Read response valid |
| rsp_hit | output | 1 | Read found data present |
| rsp_rdata | output | DATA_W | Read data |
| fetch_req_valid | output | 1 | Fetch request for a read miss |
| fetch_req_idx | output | IDX_W | Word index to fetch |
| reg_req_valid | output | 1 | Registration request |
| reg_req_idx | output | IDX_W | Registered word index |
| reg_req_core | output | CORE_W | Core ID carried by the registration |
| reg_req_map | output | MAP_W | Map ID carried by the registration |
| fill_valid | input | 1 | Fill line arrives |
| fill_line | input | LINE_W | Line number of the fill |
| fill_mask | input | WPL | Per-word fill mask |
| fill_data | input | WPL*DATA_W | Fill data, word k in lane k |
| phase_end | input | 1 | Phase/kernel boundary pulse |
| wb_start | input | 1 | Begin writeback of a word |
| wb_start_idx | input | IDX_W | Word to write back |
| wb_req_valid | output | 1 | Writeback request |
| wb_req_idx | output | IDX_W | Writeback word index |
| wb_req_data | output | DATA_W | Writeback data |
| wb_req_map | output | MAP_W | Map ID of the written-back word |
| wb_done | input | 1 | Writeback acknowledged |
| wb_done_idx | input | IDX_W | Acknowledged word index |

## Verification
On every cycle, the assertions check the per-word state rules. A written word is Registered next cycle. A Registered word stays Registered unless a writeback starts. An Invalid word changes only through a fill or a write. An acknowledged writeback frees its word. No Valid word survives a phase pulse. Each outgoing request must also follow the access that caused it. The directed scenarios are needed for the data itself: how a partial fill merges around owned words, which map ID a writeback carries, and that a write to a word in Writeback registers it again. They are also needed for the exact contents of each request.

// File: rtl/wcoh_pkg.sv
package wcoh_pkg;

  typedef enum logic [1:0] {
    W_INV = 2'b00,
    W_VAL = 2'b01,
    W_REG = 2'b10,
    W_WB  = 2'b11
  } wstate_e;

  // Next state of one word. Write wins, then the phase boundary, then the
  // per-state events.
  function automatic wstate_e wcoh_next(input wstate_e cur, input logic wr,
                                        input logic phase, input logic wbs,
                                        input logic wbd, input logic fill);
    if (wr) return W_REG;
    if (phase) return (cur == W_REG) ? (wbs ? W_WB : W_REG) : W_INV;
    case (cur)
      W_INV:   return fill ? W_VAL : W_INV;
      W_VAL:   return W_VAL;
      W_REG:   return wbs ? W_WB : W_REG;
      default: return wbd ? W_INV : W_WB;
    endcase
  endfunction

  // Fill data may replace only words this core does not own.
  function automatic logic fill_takes(input wstate_e cur);
    return (cur == W_INV) || (cur == W_VAL);
  endfunction

  function automatic logic data_present(input wstate_e cur);
    return cur != W_INV;
  endfunction

endpackage

// File: rtl/wcoh_state_array.sv
module wcoh_state_array
  import wcoh_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  phase_end,
  input  logic                  wbs_en,
  input  logic [IDX_W-1:0]      wbs_idx,
  input  logic                  wbd_en,
  input  logic [IDX_W-1:0]      wbd_idx,
  input  logic [NUM_WORDS-1:0]  fill_word_mask,
  output wstate_e [NUM_WORDS-1:0] st_o
);

  logic [NUM_WORDS-1:0] is_valid;
  logic                 any_valid;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    wstate_e st_r;
    logic    wr_hit, wbs_hit, wbd_hit;

    assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(w));
    assign wbs_hit = wbs_en && (wbs_idx == IDX_W'(w));
    assign wbd_hit = wbd_en && (wbd_idx == IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_r <= W_INV;
      else        st_r <= wcoh_next(st_r, wr_hit, phase_end, wbs_hit, wbd_hit,
                                    fill_word_mask[w]);
    end

    assign st_o[w]     = st_r;
    assign is_valid[w] = (st_r == W_VAL);

    // R4
    write_sets_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (st_r == W_REG));

    // R5
    reg_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_r == W_REG && !wbs_hit) |=> (st_r == W_REG));

    // R8
    wb_done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_r == W_WB && wbd_hit && !wr_hit) |=> (st_r == W_INV));

    // R1
    inv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_r == W_INV && !fill_word_mask[w] && !wr_hit) |=> (st_r == W_INV));
  end

  assign any_valid = |is_valid;

  // R6
  phase_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> !any_valid);

endmodule

// File: rtl/wcoh_data_array.sv
module wcoh_data_array
  import wcoh_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WPL       = 4,
  parameter int DATA_W    = 32,
  parameter int MAP_W     = 3,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [MAP_W-1:0]        wr_map,
  input  logic [NUM_WORDS-1:0]    fill_word_mask,
  input  logic [WPL*DATA_W-1:0]   fill_data,
  input  wstate_e [NUM_WORDS-1:0] st_i,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]       rd_data,
  input  logic [IDX_W-1:0]        wb_idx,
  output logic [DATA_W-1:0]       wb_data,
  output logic [MAP_W-1:0]        wb_map
);

  logic [DATA_W-1:0] data_vec [NUM_WORDS];
  logic [MAP_W-1:0]  map_vec  [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int LANE = w % WPL;
    logic [DATA_W-1:0] d_r;
    logic [MAP_W-1:0]  m_r;
    logic              wr_hit, fill_hit;

    assign wr_hit   = wr_en && (wr_idx == IDX_W'(w));
    assign fill_hit = fill_word_mask[w] && fill_takes(st_i[w]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_r <= '0;
        m_r <= '0;
      end else if (wr_hit) begin
        d_r <= wr_data;
        m_r <= wr_map;
      end else if (fill_hit) begin
        d_r <= fill_data[LANE*DATA_W +: DATA_W];
      end
    end

    assign data_vec[w] = d_r;
    assign map_vec[w]  = m_r;
  end

  assign rd_data = data_vec[rd_idx];
  assign wb_data = data_vec[wb_idx];
  assign wb_map  = map_vec[wb_idx];

endmodule

// File: rtl/wcoh_req_unit.sv
module wcoh_req_unit
  import wcoh_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32,
  parameter int CORE_W = 4,
  parameter int MAP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [MAP_W-1:0]  acc_map,
  input  logic [CORE_W-1:0] core_id,
  input  wstate_e           acc_state,
  input  logic [DATA_W-1:0] acc_rdata,
  input  logic              wbs_en,
  input  logic [IDX_W-1:0]  wbs_idx,
  input  wstate_e           wbs_state,
  input  logic [DATA_W-1:0] wbs_data,
  input  logic [MAP_W-1:0]  wbs_map,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fetch_valid,
  output logic [IDX_W-1:0]  fetch_idx,
  output logic              reg_valid,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [CORE_W-1:0] reg_core,
  output logic [MAP_W-1:0]  reg_map,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic [MAP_W-1:0]  wb_map
);

  logic rd_ev, rd_hit_ev, reg_ev, wb_ev;

  assign rd_ev     = acc_valid && !acc_write;
  assign rd_hit_ev = rd_ev && data_present(acc_state);
  assign reg_ev    = acc_valid && acc_write && (acc_state != W_REG);
  assign wb_ev     = wbs_en && (wbs_state == W_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_rdata   <= '0;
      fetch_valid <= 1'b0;
      fetch_idx   <= '0;
      reg_valid   <= 1'b0;
      reg_idx     <= '0;
      reg_core    <= '0;
      reg_map     <= '0;
      wb_valid    <= 1'b0;
      wb_idx      <= '0;
      wb_data     <= '0;
      wb_map      <= '0;
    end else begin
      rsp_valid   <= rd_ev;
      rsp_hit     <= rd_hit_ev;
      rsp_rdata   <= rd_hit_ev ? acc_rdata : '0;
      fetch_valid <= rd_ev && !rd_hit_ev;
      fetch_idx   <= acc_idx;
      reg_valid   <= reg_ev;
      if (reg_ev) begin
        reg_idx  <= acc_idx;
        reg_core <= core_id;
        reg_map  <= acc_map;
      end
      wb_valid <= wb_ev;
      if (wb_ev) begin
        wb_idx  <= wbs_idx;
        wb_data <= wbs_data;
        wb_map  <= wbs_map;
      end
    end
  end

  // R2
  fetch_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (rsp_valid && !rsp_hit));

  // R4
  reg_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> $past(acc_valid && acc_write));

  // R7
  wb_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(wbs_en));

endmodule

// File: rtl/wcoh_ctrl.sv
module wcoh_ctrl
  import wcoh_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WPL       = 4,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 4,
  parameter int MAP_W     = 3,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int OFF_W    = $clog2(WPL),
  localparam int LINE_W   = IDX_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CORE_W-1:0]     core_id,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic [DATA_W-1:0]     acc_wdata,
  input  logic [MAP_W-1:0]      acc_map_id,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  fetch_req_valid,
  output logic [IDX_W-1:0]      fetch_req_idx,
  output logic                  reg_req_valid,
  output logic [IDX_W-1:0]      reg_req_idx,
  output logic [CORE_W-1:0]     reg_req_core,
  output logic [MAP_W-1:0]      reg_req_map,
  input  logic                  fill_valid,
  input  logic [LINE_W-1:0]     fill_line,
  input  logic [WPL-1:0]        fill_mask,
  input  logic [WPL*DATA_W-1:0] fill_data,
  input  logic                  phase_end,
  input  logic                  wb_start,
  input  logic [IDX_W-1:0]      wb_start_idx,
  output logic                  wb_req_valid,
  output logic [IDX_W-1:0]      wb_req_idx,
  output logic [DATA_W-1:0]     wb_req_data,
  output logic [MAP_W-1:0]      wb_req_map,
  input  logic                  wb_done,
  input  logic [IDX_W-1:0]      wb_done_idx
);

  wstate_e [NUM_WORDS-1:0] st;
  logic [NUM_WORDS-1:0]    fill_word_mask;
  logic                    wr_en;
  wstate_e                 acc_state, wbs_state;
  logic [DATA_W-1:0]       rd_data, wbs_data;
  logic [MAP_W-1:0]        wbs_map;

  assign wr_en = acc_valid && acc_write;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      fill_word_mask[w] = fill_valid && (fill_line == LINE_W'(w / WPL)) &&
                          fill_mask[w % WPL];
    end
  end

  assign acc_state = st[acc_idx];
  assign wbs_state = st[wb_start_idx];

  wcoh_state_array #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(acc_idx),
    .phase_end(phase_end),
    .wbs_en(wb_start), .wbs_idx(wb_start_idx),
    .wbd_en(wb_done), .wbd_idx(wb_done_idx),
    .fill_word_mask(fill_word_mask),
    .st_o(st)
  );

  wcoh_data_array #(.NUM_WORDS(NUM_WORDS), .WPL(WPL), .DATA_W(DATA_W),
                    .MAP_W(MAP_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(acc_idx), .wr_data(acc_wdata), .wr_map(acc_map_id),
    .fill_word_mask(fill_word_mask), .fill_data(fill_data),
    .st_i(st),
    .rd_idx(acc_idx), .rd_data(rd_data),
    .wb_idx(wb_start_idx), .wb_data(wbs_data), .wb_map(wbs_map)
  );

  wcoh_req_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CORE_W(CORE_W),
                  .MAP_W(MAP_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx),
    .acc_map(acc_map_id), .core_id(core_id),
    .acc_state(acc_state), .acc_rdata(rd_data),
    .wbs_en(wb_start), .wbs_idx(wb_start_idx), .wbs_state(wbs_state),
    .wbs_data(wbs_data), .wbs_map(wbs_map),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .fetch_valid(fetch_req_valid), .fetch_idx(fetch_req_idx),
    .reg_valid(reg_req_valid), .reg_idx(reg_req_idx),
    .reg_core(reg_req_core), .reg_map(reg_req_map),
    .wb_valid(wb_req_valid), .wb_idx(wb_req_idx),
    .wb_data(wb_req_data), .wb_map(wb_req_map)
  );

  // R4
  unowned_write_registers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_state != W_REG) |=> reg_req_valid);

  // R5
  owned_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_state == W_REG) |=> !reg_req_valid);

endmodule

// File: tb/wcoh_ctrl_tb_top.sv
module wcoh_ctrl_tb_top;

  localparam int NW = 32, WPL = 4, DW = 32, CW = 4, MW = 3;
  localparam int IW = $clog2(NW), LW = IW - $clog2(WPL);
  localparam logic [CW-1:0] MY_CORE = 4'h5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [CW-1:0] core_id = MY_CORE;
  logic acc_valid = 0, acc_write = 0;
  logic [IW-1:0] acc_idx = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [MW-1:0] acc_map_id = '0;
  logic rsp_valid, rsp_hit, fetch_req_valid, reg_req_valid, wb_req_valid;
  logic [DW-1:0] rsp_rdata, wb_req_data;
  logic [IW-1:0] fetch_req_idx, reg_req_idx, wb_req_idx;
  logic [CW-1:0] reg_req_core;
  logic [MW-1:0] reg_req_map, wb_req_map;
  logic fill_valid = 0;
  logic [LW-1:0] fill_line = '0;
  logic [WPL-1:0] fill_mask = '0;
  logic [WPL*DW-1:0] fill_data = '0;
  logic phase_end = 0, wb_start = 0, wb_done = 0;
  logic [IW-1:0] wb_start_idx = '0, wb_done_idx = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  wcoh_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .core_id(core_id),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .acc_map_id(acc_map_id),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .fetch_req_valid(fetch_req_valid), .fetch_req_idx(fetch_req_idx),
    .reg_req_valid(reg_req_valid), .reg_req_idx(reg_req_idx),
    .reg_req_core(reg_req_core), .reg_req_map(reg_req_map),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_mask(fill_mask),
    .fill_data(fill_data), .phase_end(phase_end),
    .wb_start(wb_start), .wb_start_idx(wb_start_idx),
    .wb_req_valid(wb_req_valid), .wb_req_idx(wb_req_idx),
    .wb_req_data(wb_req_data), .wb_req_map(wb_req_map),
    .wb_done(wb_done), .wb_done_idx(wb_done_idx)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; registered outputs are sampled at the
  // next falling edge, one rising edge later.
  task automatic do_read(input int idx, input bit hit, input logic [DW-1:0] data, input string req);
    acc_valid = 1; acc_write = 0; acc_idx = IW'(idx);
    @(negedge clk);
    acc_valid = 0;
    check({req, " rsp_valid"}, 64'(rsp_valid), 64'(1));
    check({req, " rsp_hit"}, 64'(rsp_hit), 64'(hit));
    if (hit) check({req, " rsp_rdata"}, 64'(rsp_rdata), 64'(data));
    check({req, " fetch_req_valid"}, 64'(fetch_req_valid), 64'(!hit));
    if (!hit) check({req, " fetch_req_idx"}, 64'(fetch_req_idx), 64'(idx));
  endtask

  task automatic do_write(input int idx, input logic [DW-1:0] data, input logic [MW-1:0] map,
                          input bit exp_reg, input string req, input bit with_phase = 0);
    acc_valid = 1; acc_write = 1; acc_idx = IW'(idx); acc_wdata = data;
    acc_map_id = map; phase_end = with_phase;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; phase_end = 0;
    check({req, " reg_req_valid"}, 64'(reg_req_valid), 64'(exp_reg));
    if (exp_reg) begin
      check({req, " reg_req_idx"}, 64'(reg_req_idx), 64'(idx));
      check({req, " reg_req_core"}, 64'(reg_req_core), 64'(MY_CORE));
      check({req, " reg_req_map"}, 64'(reg_req_map), 64'(map));
    end
  endtask

  task automatic do_fill(input int line, input logic [WPL-1:0] mask, input logic [WPL*DW-1:0] data);
    fill_valid = 1; fill_line = LW'(line); fill_mask = mask; fill_data = data;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_phase();
    phase_end = 1;
    @(negedge clk);
    phase_end = 0;
  endtask

  task automatic do_wb_start(input int idx, input bit exp, input logic [DW-1:0] data,
                             input logic [MW-1:0] map, input string req);
    wb_start = 1; wb_start_idx = IW'(idx);
    @(negedge clk);
    wb_start = 0;
    check({req, " wb_req_valid"}, 64'(wb_req_valid), 64'(exp));
    if (exp) begin
      check({req, " wb_req_idx"}, 64'(wb_req_idx), 64'(idx));
      check({req, " wb_req_data"}, 64'(wb_req_data), 64'(data));
      check({req, " wb_req_map"}, 64'(wb_req_map), 64'(map));
    end
  endtask

  task automatic do_wb_done(input int idx);
    wb_done = 1; wb_done_idx = IW'(idx);
    @(negedge clk);
    wb_done = 0;
  endtask

  task automatic t_reset();
    check("R1 no rsp after reset", 64'(rsp_valid), 64'(0));
    check("R1 no reg req after reset", 64'(reg_req_valid), 64'(0));
    do_read(0, 0, '0, "R1 word0 invalid");
    do_read(31, 0, '0, "R1 word31 invalid");
  endtask

  task automatic t_partial_fill();
    do_fill(0, 4'b0101, {32'hA0A00003, 32'hA0A00002, 32'hA0A00001, 32'hA0A00000});
    do_read(0, 1, 32'hA0A00000, "R3 partial fill lane0");
    do_read(2, 1, 32'hA0A00002, "R3 partial fill lane2");
    do_read(1, 0, '0, "R3 unmasked lane1");
    do_read(3, 0, '0, "R3 unmasked lane3");
  endtask

  task automatic t_register();
    do_write(1, 32'h11110001, 3'd3, 1, "R4 first write registers");
    do_write(1, 32'h11110002, 3'd3, 0, "R5 owned write silent");
    do_read(1, 1, 32'h11110002, "R5 read owned");
  endtask

  task automatic t_merge();
    do_fill(0, 4'b1111, {32'hB0B00003, 32'hB0B00002, 32'hB0B00001, 32'hB0B00000});
    do_read(0, 1, 32'hB0B00000, "R3 valid refreshed");
    do_read(1, 1, 32'h11110002, "R3 owned word kept");
    do_read(2, 1, 32'hB0B00002, "R3 valid refreshed lane2");
    do_read(3, 1, 32'hB0B00003, "R3 invalid filled");
  endtask

  task automatic t_phase();
    do_phase();
    do_read(0, 0, '0, "R6 valid self-invalidated");
    do_read(3, 0, '0, "R6 valid lane3 self-invalidated");
    do_read(1, 1, 32'h11110002, "R6 registered survives");
    do_write(1, 32'h11110003, 3'd3, 0, "R6 still registered");
  endtask

  task automatic t_writeback();
    do_wb_start(1, 1, 32'h11110003, 3'd3, "R7 wb of owned word");
    do_wb_start(0, 0, '0, '0, "R7 wb on invalid ignored");
    do_read(1, 1, 32'h11110003, "R7 wb word still hits");
    do_wb_done(1);
    do_read(1, 0, '0, "R8 wb done frees word");
    do_write(9, 32'h99990000, 3'd1, 1, "R4 word9");
    do_wb_done(9);
    do_read(9, 1, 32'h99990000, "R8 done on registered ignored");
    do_write(9, 32'h99990001, 3'd1, 0, "R8 word9 still registered");
  endtask

  task automatic t_rewrite_and_phase();
    do_write(5, 32'h55550000, 3'd2, 1, "R4 word5");
    do_wb_start(5, 1, 32'h55550000, 3'd2, "R7 wb word5");
    do_write(5, 32'h55550001, 3'd6, 1, "R4 write in writeback reregisters");
    do_write(6, 32'h66660000, 3'd4, 1, "R4 word6");
    do_wb_start(6, 1, 32'h66660000, 3'd4, "R7 wb word6");
    do_phase();
    do_read(6, 0, '0, "R6 writeback word invalidated");
    do_write(12, 32'hCCCC0000, 3'd5, 1, "R4 word12");
    do_wb_start(12, 1, 32'hCCCC0000, 3'd5, "R7 wb word12");
    do_fill(3, 4'b0001, {32'h0, 32'h0, 32'h0, 32'hDDDD0000});
    do_read(12, 1, 32'hCCCC0000, "R3 fill skips writeback word");
    do_write(7, 32'h77770000, 3'd0, 1, "R6 write with phase", 1);
    do_read(7, 1, 32'h77770000, "R6 same-cycle write survives");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_partial_fill();
    t_register();
    t_merge();
    t_phase();
    t_writeback();
    t_rewrite_and_phase();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule